// File: doc/BRIEF.md
# Write-Protected Nonvolatile Memory Controller

This block sits between a CPU write port and a word-addressed nonvolatile storage array, which is modelled here as an internal register array. The CPU reaches either the array or a small register space through one port. The register space holds a protected control register (a write-protect bit, a 4-bit wait-state field and a stored-only automatic wait-state bit), an interrupt-enable register and a status register of error flags. While write protection is on, CPU writes to the array are dropped and a protection-violation flag is raised. That flag can drive the interrupt output.

A separate debug port, used by loaders and debuggers, always writes the array. It never raises the violation flag. The remaining flags stand for an access-time error, an uncorrectable-bit error and a correctable-bit error. No detection logic is modelled for them; dedicated test inputs set them. Every status flag is cleared by writing 0 to its bit. Writing 1 leaves it alone.

The CPU port uses a valid/ready pair. `cpu_ready` is held high, so every valid beat is accepted in the cycle it is presented and there is never back-pressure. Register and array reads return data combinationally in the same cycle as the request.

Top module: `nvm_wp_ctrl`

## Requirements
- R1: After reset, the control register reads 0x9600 (read key 0x96 in bits 15..8, all fields 0), the enable and status registers read 0, `irq` is 0 and `cpu_ready` is 1.
- R2: With write protection off, a CPU array write (`cpu_sel_reg`=0) stores its data, and a later CPU array read of that address returns it.
- R3: With write protection on, a CPU array write leaves the array word unchanged and sets status bit 4 on the following clock edge.
- R4: Status register (register index 2) bits are: 4 protection violation, 3 access-time error, 2 uncorrectable bit, 1 correctable bit. Writing 0 to a bit clears that flag. Writing 1 to it leaves the flag unchanged.
- R5: If a flag's set event and a write-0 to that flag occur in the same cycle, the flag ends up set.
- R6: A write to the control register (register index 0) takes effect only when bits 15..8 equal 0xA5. Otherwise the register is unchanged. The stored fields are: bit 0 write protect, bit 3 automatic wait-state (stored, no effect), bits 7..4 wait-state count. Bits 2..1 read 0.
- R7: A debug-port write always stores its data, even while protection is on, and never sets status bit 4.
- R8: The interrupt-enable register (register index 1) uses the same bit positions as the status register: bit 4 enables the violation interrupt and bit 3 enables the access-time interrupt. `irq` is the OR of each flag ANDed with its enable, and it reflects any register change from the next clock edge onward.
- R9: If the CPU and the debug port write the same array address in the same cycle, the debug data is kept.
- R10: A one-cycle pulse on `err_acc_set`, `err_ubd_set` or `err_cbd_set` sets status bit 3, 2 or 1 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted (always 1) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel_reg | input | 1 | 1 = register space (index in address bits 1..0), 0 = array |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed location |
| dbg_we | input | 1 | Debug array write strobe |
| dbg_addr | input | ADDR_W | Debug word address (write and read) |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rdata | output | 16 | Array word at `dbg_addr` |
| err_acc_set | input | 1 | Test input: set access-time error flag |
| err_ubd_set | input | 1 | Test input: set uncorrectable-bit flag |
| err_cbd_set | input | 1 | Test input: set correctable-bit flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the CPU presents at most one request per cycle and that `cpu_we` and `cpu_sel_reg` only have meaning while `cpu_valid` is high. They also assume that the test error inputs are single-cycle pulses, so the state they check before the edge belongs to a single event. The bench drives each request for exactly one cycle, between falling edges, and returns `cpu_valid` to 0 afterwards. It reads only array addresses it has already written, so no assertion or check ever sees uninitialised storage. It raises an error input together with a status write only in the directed case that exercises the set-over-clear rule.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    RI_CTL = 2'd0,
    RI_IE  = 2'd1,
    RI_ST  = 2'd2,
    RI_RSV = 2'd3
  } reg_idx_e;

  localparam logic [7:0] PW_KEY     = 8'hA5;
  localparam logic [7:0] RD_KEY     = 8'h96;
  localparam logic [7:0] CTL_MASK   = 8'hF9;
  localparam int         BIT_WP     = 4;
  localparam int         BIT_ACC    = 3;
  localparam int         BIT_UBD    = 2;
  localparam int         BIT_CBD    = 1;
  localparam int         FLAG_LO    = 1;
  localparam int         FLAG_HI    = 4;
endpackage

// File: rtl/nvm_wr_gate.sv
module nvm_wr_gate (
  input  logic arr_wr,
  input  logic wp_on,
  output logic pass,
  output logic blocked
);
  always_comb begin
    pass    = arr_wr & ~wp_on;
    blocked = arr_wr &  wp_on;
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] cpu_rword,
  output logic [DATA_W-1:0] dbg_rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Debug port is applied last so it wins an address collision.
  always_ff @(posedge clk) begin
    if (cpu_we) mem[cpu_addr] <= cpu_wdata;
    if (dbg_we) mem[dbg_addr] <= dbg_wdata;
  end

  assign cpu_rword = mem[cpu_addr];
  assign dbg_rword = mem[dbg_addr];

  assert_dbg_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> (mem[$past(dbg_addr)] == $past(dbg_wdata)));
endmodule

// File: rtl/nvm_ctl_regs.sv
module nvm_ctl_regs
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              blocked,
  input  logic              err_acc,
  input  logic              err_ubd,
  input  logic              err_cbd,
  output logic              wp_on,
  output logic              irq
);
  logic [7:0]             ctl_q;
  logic [FLAG_HI:FLAG_LO] ie_q;
  logic [FLAG_HI:FLAG_LO] flag_q;
  logic [FLAG_HI:FLAG_LO] set_vec;
  logic                   ctl_wr;
  logic                   ctl_key_ok;
  logic                   ie_wr;
  logic                   st_wr;

  assign ctl_wr     = wr_en && (reg_idx_e'(wr_idx) == RI_CTL);
  assign ctl_key_ok = (wr_data[15:8] == PW_KEY);
  assign ie_wr      = wr_en && (reg_idx_e'(wr_idx) == RI_IE);
  assign st_wr      = wr_en && (reg_idx_e'(wr_idx) == RI_ST);

  always_ff @(posedge clk) begin
    if (!rst_n)                     ctl_q <= '0;
    else if (ctl_wr && ctl_key_ok)  ctl_q <= wr_data[7:0] & CTL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_wr) ie_q <= wr_data[FLAG_HI:FLAG_LO];
  end

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_WP]  = blocked;
    set_vec[BIT_ACC] = err_acc;
    set_vec[BIT_UBD] = err_ubd;
    set_vec[BIT_CBD] = err_cbd;
  end

  for (genvar b = FLAG_LO; b <= FLAG_HI; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                  flag_q[b] <= 1'b0;
      else if (set_vec[b])         flag_q[b] <= 1'b1;
      else if (st_wr && !wr_data[b]) flag_q[b] <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> flag_q[b]);

    assert_w1_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wr_data[b] && flag_q[b]) |=> flag_q[b]);
  end

  assign wp_on = ctl_q[0];
  assign irq   = |(flag_q & ie_q);

  always_comb begin
    rd_data = '0;
    unique case (reg_idx_e'(rd_idx))
      RI_CTL: rd_data = {RD_KEY, ctl_q};
      RI_IE:  rd_data[FLAG_HI:FLAG_LO] = ie_q;
      RI_ST:  rd_data[FLAG_HI:FLAG_LO] = flag_q;
      RI_RSV: rd_data = '0;
    endcase
  end

  assert_pw_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_key_ok) |=> $stable(ctl_q));
endmodule

// File: rtl/nvm_wp_ctrl.sv
module nvm_wp_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic              cpu_sel_reg,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              err_acc_set,
  input  logic              err_ubd_set,
  input  logic              err_cbd_set,
  output logic              irq
);
  logic              arr_wr;
  logic              reg_wr;
  logic              arr_pass;
  logic              arr_blocked;
  logic              wp_on;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] arr_rdata;

  assign cpu_ready = 1'b1;
  assign arr_wr    = cpu_valid & cpu_we & ~cpu_sel_reg;
  assign reg_wr    = cpu_valid & cpu_we &  cpu_sel_reg;

  nvm_wr_gate u_gate (
    .arr_wr  (arr_wr),
    .wp_on   (wp_on),
    .pass    (arr_pass),
    .blocked (arr_blocked)
  );

  nvm_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (cpu_addr[1:0]),
    .wr_data (cpu_wdata),
    .rd_idx  (cpu_addr[1:0]),
    .rd_data (reg_rdata),
    .blocked (arr_blocked),
    .err_acc (err_acc_set),
    .err_ubd (err_ubd_set),
    .err_cbd (err_cbd_set),
    .wp_on   (wp_on),
    .irq     (irq)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (arr_pass),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .cpu_rword (arr_rdata),
    .dbg_rword (dbg_rdata)
  );

  assign cpu_rdata = cpu_sel_reg ? reg_rdata : arr_rdata;

  logic st_wr;
  assign st_wr = reg_wr && (reg_idx_e'(cpu_addr[1:0]) == RI_ST);

  assert_blocked_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && wp_on) |=> reg_rdata_flag_seen);

  logic reg_rdata_flag_seen;
  assign reg_rdata_flag_seen = u_regs.flag_q[BIT_WP];

  assert_blocked_keeps_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && wp_on && !dbg_we) |=> (u_array.mem[$past(cpu_addr)] == $past(arr_rdata)));

  assert_dbg_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !arr_wr && !st_wr) |=> $stable(reg_rdata_flag_seen));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && wp_on && u_regs.ie_q[BIT_WP] && !(reg_wr && reg_idx_e'(cpu_addr[1:0]) == RI_IE)) |=> irq);
endmodule

// File: tb/tb_nvm_wp_ctrl.sv
module tb_nvm_wp_ctrl;
  localparam int AW = 6;
  localparam logic [2:0] OP_CW = 3'd0, OP_RW = 3'd1, OP_DW = 3'd2,
                         OP_CR = 3'd3, OP_RR = 3'd4, OP_DR = 3'd5, OP_IQ = 3'd6;
  localparam int N_VEC = 31;

  // {req[3:0], op[2:0], addr[7:0], data[15:0], expect[15:0]}
  localparam logic [46:0] VEC [N_VEC] = '{
    {4'd2, OP_CW, 8'd3,  16'h1234, 16'h0000},  // R2
    {4'd2, OP_CR, 8'd3,  16'h0000, 16'h1234},
    {4'd2, OP_CW, 8'd10, 16'hBEEF, 16'h0000},
    {4'd2, OP_CR, 8'd10, 16'h0000, 16'hBEEF},
    {4'd6, OP_RW, 8'd0,  16'h3371, 16'h0000},  // R6 wrong key
    {4'd6, OP_RR, 8'd0,  16'h0000, 16'h9600},
    {4'd6, OP_RW, 8'd0,  16'hA5F9, 16'h0000},  // R6 key ok, protect on
    {4'd6, OP_RR, 8'd0,  16'h0000, 16'h96F9},
    {4'd3, OP_CW, 8'd3,  16'h5555, 16'h0000},  // R3 blocked
    {4'd3, OP_CR, 8'd3,  16'h0000, 16'h1234},
    {4'd3, OP_RR, 8'd2,  16'h0000, 16'h0010},
    {4'd7, OP_DW, 8'd10, 16'hCAFE, 16'h0000},  // R7 debug bypass
    {4'd7, OP_DR, 8'd10, 16'h0000, 16'hCAFE},
    {4'd7, OP_CR, 8'd10, 16'h0000, 16'hCAFE},
    {4'd8, OP_IQ, 8'd0,  16'h0000, 16'h0000},  // R8 no enable
    {4'd8, OP_RW, 8'd1,  16'h0010, 16'h0000},
    {4'd8, OP_IQ, 8'd0,  16'h0000, 16'h0001},
    {4'd4, OP_RW, 8'd2,  16'h0010, 16'h0000},  // R4 write 1 keeps
    {4'd4, OP_RR, 8'd2,  16'h0000, 16'h0010},
    {4'd4, OP_RW, 8'd2,  16'hFFEF, 16'h0000},  // R4 write 0 clears
    {4'd4, OP_RR, 8'd2,  16'h0000, 16'h0000},
    {4'd8, OP_IQ, 8'd0,  16'h0000, 16'h0000},
    {4'd7, OP_DW, 8'd11, 16'h0F0F, 16'h0000},  // R7 no flag
    {4'd7, OP_RR, 8'd2,  16'h0000, 16'h0000},
    {4'd7, OP_DR, 8'd11, 16'h0000, 16'h0F0F},
    {4'd6, OP_RW, 8'd0,  16'hA500, 16'h0000},  // R6 protect off
    {4'd6, OP_RR, 8'd0,  16'h0000, 16'h9600},
    {4'd2, OP_CW, 8'd3,  16'h7777, 16'h0000},
    {4'd2, OP_CR, 8'd3,  16'h0000, 16'h7777},
    {4'd3, OP_RR, 8'd2,  16'h0000, 16'h0000},
    {4'd8, OP_RR, 8'd1,  16'h0000, 16'h0010}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0, cpu_sel_reg = 1'b0;
  logic [AW-1:0] cpu_addr = '0, dbg_addr = '0;
  logic [15:0]   cpu_wdata = '0, dbg_wdata = '0;
  logic          dbg_we = 1'b0;
  logic          err_acc_set = 1'b0, err_ubd_set = 1'b0, err_cbd_set = 1'b0;
  logic          cpu_ready, irq;
  logic [15:0]   cpu_rdata, dbg_rdata;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  nvm_wp_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_sel_reg(cpu_sel_reg), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .err_acc_set(err_acc_set), .err_ubd_set(err_ubd_set), .err_cbd_set(err_cbd_set),
    .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_sel_reg = sel; cpu_addr = a[AW-1:0]; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic dbg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = a[AW-1:0]; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic cpu_read(input logic sel, input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_sel_reg = sel; cpu_addr = a[AW-1:0];
    #1 v = cpu_rdata;
    cpu_valid = 1'b0;
  endtask

  task automatic dbg_read(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    dbg_addr = a[AW-1:0];
    #1 v = dbg_rdata;
  endtask

  task automatic irq_read(output logic [15:0] v);
    @(negedge clk);
    #1 v = {15'd0, irq};
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cpu_read(1'b1, 8'd0, v); check("R1 ctl", v, 16'h9600);
    cpu_read(1'b1, 8'd1, v); check("R1 ie", v, 16'h0000);
    cpu_read(1'b1, 8'd2, v); check("R1 status", v, 16'h0000);
    irq_read(v);             check("R1 irq", v, 16'h0000);
    check("R1 ready", {15'd0, cpu_ready}, 16'h0001);

    for (int i = 0; i < N_VEC; i++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [7:0]  ad;
      logic [15:0] dt, ex;
      string       tag;
      {rq, op, ad, dt, ex} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        OP_CW: cpu_write(1'b0, ad, dt);
        OP_RW: cpu_write(1'b1, ad, dt);
        OP_DW: dbg_write(ad, dt);
        OP_CR: begin cpu_read(1'b0, ad, v); check(tag, v, ex); end
        OP_RR: begin cpu_read(1'b1, ad, v); check(tag, v, ex); end
        OP_DR: begin dbg_read(ad, v); check(tag, v, ex); end
        default: begin irq_read(v); check(tag, v, ex); end
      endcase
    end

    // R10 access-time flag via test input, R8 irq via its enable bit 3
    cpu_write(1'b1, 8'd1, 16'h0008);
    @(negedge clk); err_acc_set = 1'b1;
    @(negedge clk); err_acc_set = 1'b0;
    cpu_read(1'b1, 8'd2, v); check("R10 acc flag", v, 16'h0008);
    irq_read(v);             check("R8 acc irq", v, 16'h0001);

    // R5 set and write-0 clear in the same cycle: set wins
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_sel_reg = 1'b1; cpu_addr = 6'd2; cpu_wdata = 16'h0000;
    err_acc_set = 1'b1;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0; err_acc_set = 1'b0;
    cpu_read(1'b1, 8'd2, v); check("R5 set wins", v, 16'h0008);
    cpu_write(1'b1, 8'd2, 16'h0000);
    cpu_read(1'b1, 8'd2, v); check("R4 clear acc", v, 16'h0000);
    irq_read(v);             check("R8 irq drops", v, 16'h0000);

    // R10 bit 2 and bit 1; R8 they are not enabled
    @(negedge clk); err_ubd_set = 1'b1; err_cbd_set = 1'b1;
    @(negedge clk); err_ubd_set = 1'b0; err_cbd_set = 1'b0;
    cpu_read(1'b1, 8'd2, v); check("R10 ubd cbd", v, 16'h0006);
    irq_read(v);             check("R8 masked", v, 16'h0000);

    // R9 same-address collision, debug wins
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_sel_reg = 1'b0; cpu_addr = 6'd20; cpu_wdata = 16'h1111;
    dbg_we = 1'b1; dbg_addr = 6'd20; dbg_wdata = 16'h2222;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0; dbg_we = 1'b0;
    cpu_read(1'b0, 8'd20, v); check("R9 debug wins", v, 16'h2222);
    check("R1 ready held", {15'd0, cpu_ready}, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule